// File: doc/BRIEF.md
# Ethernet Event Interrupt Register

This block collects event pulses from an Ethernet channel controller into a sticky 16-bit event register. It pairs that register with a mask register and drives a single level-sensitive interrupt request. The transmit and receive engines report events as single-cycle pulses. A small graceful-stop tracker watches the stop command and the frame-in-progress level, and raises its own completion event. Software reads either register through a one-bit-addressed register bus. It clears event bits by writing ones to the event register, and it loads the mask register with plain writes.

The graceful-stop tracker is a two-state machine. In `GS_IDLE`, a stop command while no frame is in flight produces the completion event at once, and the machine stays in `GS_IDLE`. A stop command while a frame is in flight takes the transition `GS_IDLE -> GS_DRAIN`. In `GS_DRAIN`, further stop commands are ignored. The machine takes the transition `GS_DRAIN -> GS_IDLE`, raising the completion event, in the first cycle the frame-in-progress level is seen low. Otherwise it stays in `GS_DRAIN`.

The interrupt output is registered. It reflects whether any bit is pending in both registers in the previous cycle, so it stays high until the last unmasked pending bit has been cleared.

Top module: `eth_evt_irq`

## Requirements
- R1: Event bit positions are: bit 7 graceful-stop complete, bit 4 transmit error, bit 3 received complete frame, bit 2 frame dropped for lack of buffers, bit 1 transmit buffer done, bit 0 partial-frame buffer received. A pulse sampled at a clock edge makes its bit read as 1 at `bus_rdata` (with `bus_addr`=0) right after that edge.
- R2: Bits 15..8 and 6..5 of both registers always read 0, and writes to them have no effect.
- R3: A set event bit stays set until software clears it.
- R4: A write to address 0 clears every bit written as 1 and leaves every bit written as 0 unchanged. Several bits may be cleared in one write.
- R5: Reading either register, any number of times, changes no state.
- R6: A write to address 1 loads the mask register with the written value on bits 7 and 4..0. The value reads back at address 1 from the next cycle.
- R7: `irq` is registered. It is 1 in the cycle after a cycle in which any bit is set in both the event and the mask register, and 0 otherwise. A masked event never raises it, and it falls one cycle after the last unmasked pending bit is cleared.
- R8: If an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R9: Reset (`rst_n` low) clears both registers, `irq` and the tracker state.
- R10: A stop command while `tx_active` is 0 sets bit 7 at the same edge that samples the command (`GS_IDLE` stays `GS_IDLE`).
- R11: A stop command while `tx_active` is 1 enters `GS_DRAIN`, and bit 7 stays 0 while `tx_active` stays 1. Bit 7 is set at the first edge that samples `tx_active` low, which also returns the machine to `GS_IDLE`. Stop commands seen in `GS_DRAIN` produce no additional event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Register select: 0 event, 1 mask |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| tx_err_p | input | 1 | Transmit error pulse |
| rx_frame_p | input | 1 | Complete frame received pulse |
| rx_nobuf_p | input | 1 | Frame dropped, no buffer pulse |
| tx_buf_p | input | 1 | Transmit buffer done pulse |
| rx_part_p | input | 1 | Partial-frame buffer received pulse |
| gstop_cmd | input | 1 | Graceful-stop command pulse |
| tx_active | input | 1 | Level: a frame is being transmitted |
| irq | output | 1 | Level interrupt request |

## Verification
A lost or spurious event bit shows at `bus_rdata` in the cycle right after the edge that should have set or cleared it. A wrong pending state shows on `irq` one cycle after that. A tracker stuck in `GS_DRAIN` shows as a missing bit 7 after a later idle-line stop command. A tracker that leaves `GS_DRAIN` early shows as bit 7 rising while `tx_active` is still high. A reference model of both registers, the tracker and the interrupt flop is compared against the read data and `irq` every cycle, so any divergence is reported within one cycle of its first visible effect.

// File: rtl/eth_evt_pkg.sv
`timescale 1ns/1ps
package eth_evt_pkg;
    localparam int REG_W = 16;
    localparam int B_RXB = 0;
    localparam int B_TXB = 1;
    localparam int B_BSY = 2;
    localparam int B_RXF = 3;
    localparam int B_TXE = 4;
    localparam int B_GSD = 7;
    localparam logic [REG_W-1:0] IMPL_BITS = REG_W'((1 << B_RXB) | (1 << B_TXB) |
        (1 << B_BSY) | (1 << B_RXF) | (1 << B_TXE) | (1 << B_GSD));
    localparam logic ADDR_EVT  = 1'b0;
    localparam logic ADDR_MASK = 1'b1;

    typedef enum logic [0:0] {
        GS_IDLE  = 1'b0,
        GS_DRAIN = 1'b1
    } gs_state_t;
endpackage

// File: rtl/eth_evt_gstop.sv
`timescale 1ns/1ps
module eth_evt_gstop
    import eth_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gs_cmd,
    input  logic tx_active,
    output logic gs_done
);
    gs_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE:  if (gs_cmd && tx_active) state_d = GS_DRAIN;
            GS_DRAIN: if (!tx_active)          state_d = GS_IDLE;
            default:                           state_d = GS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        gs_done = 1'b0;
        unique case (state_q)
            GS_IDLE:  gs_done = gs_cmd && !tx_active;
            GS_DRAIN: gs_done = !tx_active;
            default:  gs_done = 1'b0;
        endcase
    end
endmodule

// File: rtl/eth_evt_bank.sv
`timescale 1ns/1ps
module eth_evt_bank
    import eth_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] clr_vec,
    input  logic             mask_we,
    input  logic [REG_W-1:0] mask_wdata,
    output logic [REG_W-1:0] evt_q,
    output logic [REG_W-1:0] mask_q,
    output logic             irq_q
);
    logic [REG_W-1:0] evt_d, mask_d;

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL_BITS[i]) begin : g_impl
            // set has priority over a clear in the same cycle
            assign evt_d[i]  = set_vec[i] | (evt_q[i] & ~clr_vec[i]);
            assign mask_d[i] = mask_we ? mask_wdata[i] : mask_q[i];
        end else begin : g_rsvd
            assign evt_d[i]  = 1'b0;
            assign mask_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q  <= '0;
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            evt_q  <= evt_d;
            mask_q <= mask_d;
            irq_q  <= |(evt_q & mask_q);
        end
    end
endmodule

// File: rtl/eth_evt_irq.sv
`timescale 1ns/1ps
module eth_evt_irq
    import eth_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_addr,
    input  logic        bus_we,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        tx_err_p,
    input  logic        rx_frame_p,
    input  logic        rx_nobuf_p,
    input  logic        tx_buf_p,
    input  logic        rx_part_p,
    input  logic        gstop_cmd,
    input  logic        tx_active,
    output logic        irq
);
    logic             gs_done;
    logic [REG_W-1:0] set_vec, clr_vec, evt_q, mask_q;
    logic             mask_we;

    eth_evt_gstop u_gstop (
        .clk       (clk),
        .rst_n     (rst_n),
        .gs_cmd    (gstop_cmd),
        .tx_active (tx_active),
        .gs_done   (gs_done)
    );

    always_comb begin
        set_vec        = '0;
        set_vec[B_RXB] = rx_part_p;
        set_vec[B_TXB] = tx_buf_p;
        set_vec[B_BSY] = rx_nobuf_p;
        set_vec[B_RXF] = rx_frame_p;
        set_vec[B_TXE] = tx_err_p;
        set_vec[B_GSD] = gs_done;
    end

    assign clr_vec = (bus_we && bus_addr == ADDR_EVT) ? bus_wdata : '0;
    assign mask_we = bus_we && bus_addr == ADDR_MASK;

    eth_evt_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .clr_vec    (clr_vec),
        .mask_we    (mask_we),
        .mask_wdata (bus_wdata),
        .evt_q      (evt_q),
        .mask_q     (mask_q),
        .irq_q      (irq)
    );

    assign bus_rdata = (bus_addr == ADDR_MASK) ? mask_q : evt_q;
endmodule

// File: rtl/eth_evt_irq_chk.sv
`timescale 1ns/1ps
module eth_evt_irq_chk
    import eth_evt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_addr,
    input logic             bus_we,
    input logic [15:0]      bus_wdata,
    input logic             tx_err_p,
    input logic             tx_active,
    input logic [REG_W-1:0] evt_q,
    input logic [REG_W-1:0] mask_q,
    input logic             irq
);
    logic [REG_W-1:0] clr_c;
    logic             mwr_c;
    assign clr_c = (bus_we && bus_addr == ADDR_EVT) ? bus_wdata : '0;
    assign mwr_c = bus_we && bus_addr == ADDR_MASK;

    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_q) & ~$past(clr_c) & ~evt_q) == '0));

    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mwr_c |=> $stable(mask_q));

    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mwr_c |=> (mask_q == ($past(bus_wdata) & IMPL_BITS)));

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err_p |=> evt_q[B_TXE]);

    a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err_p && mask_q[B_TXE] && !mwr_c) |=> ##1 irq);

    a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q == '0) |=> !irq);

    a_r11_no_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_q[B_GSD]) |-> !$past(tx_active));
endmodule

bind eth_evt_irq eth_evt_irq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .tx_err_p  (tx_err_p),
    .tx_active (tx_active),
    .evt_q     (evt_q),
    .mask_q    (mask_q),
    .irq       (irq)
);

// File: tb/eth_evt_irq_tb_top.sv
`timescale 1ns/1ps
module eth_evt_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tx_err_p = 0, rx_frame_p = 0, rx_nobuf_p = 0, tx_buf_p = 0, rx_part_p = 0;
    logic        gstop_cmd = 0, tx_active = 0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    eth_evt_irq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_err_p(tx_err_p),
        .rx_frame_p(rx_frame_p), .rx_nobuf_p(rx_nobuf_p), .tx_buf_p(tx_buf_p),
        .rx_part_p(rx_part_p), .gstop_cmd(gstop_cmd), .tx_active(tx_active), .irq(irq)
    );

    // behavioural reference model
    localparam logic [15:0] LIVE = 16'h009F;
    logic [15:0] m_evt = '0;
    logic [15:0] m_mask = '0;
    logic        m_irq = 1'b0;
    bit          m_waiting = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_evt = '0; m_mask = '0; m_irq = 0; m_waiting = 0;
        end else begin
            logic [15:0] s, c;
            logic        nirq, done;
            nirq = (m_evt & m_mask) != 0;
            done = 0;
            if (m_waiting) begin
                if (!tx_active) begin done = 1; m_waiting = 0; end
            end else if (gstop_cmd) begin
                if (tx_active) m_waiting = 1; else done = 1;
            end
            s = {8'h00, done, 2'b00, tx_err_p, rx_frame_p, rx_nobuf_p, tx_buf_p, rx_part_p};
            c = (bus_we && !bus_addr) ? bus_wdata : 16'h0000;
            m_evt = ((m_evt & ~c) | s) & LIVE;
            if (bus_we && bus_addr) m_mask = bus_wdata & LIVE;
            m_irq = nirq;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 model rdata", bus_rdata, bus_addr ? m_mask : m_evt);
            chk("R7 model irq", {15'h0, irq}, {15'h0, m_irq});
        end
    end

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic rd(input logic a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        tick();
        bus_we = 0; bus_wdata = '0; bus_addr = 0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R9 reset state
        rd(0, v); chk("R9 evt after reset", v, 16'h0000);
        rd(1, v); chk("R9 mask after reset", v, 16'h0000);
        chk("R9 irq after reset", {15'h0, irq}, 16'h0);

        // R1 bit positions, masked so R7 no irq
        tx_err_p = 1; tick(); tx_err_p = 0;
        rd(0, v); chk("R1 tx error bit4", v, 16'h0010);
        rx_frame_p = 1; tick(); rx_frame_p = 0;
        rd(0, v); chk("R1 rx frame bit3", v, 16'h0018);
        rx_nobuf_p = 1; tick(); rx_nobuf_p = 0;
        rd(0, v); chk("R1 no buffer bit2", v, 16'h001C);
        tx_buf_p = 1; tick(); tx_buf_p = 0;
        rd(0, v); chk("R1 tx buffer bit1", v, 16'h001E);
        rx_part_p = 1; tick(); rx_part_p = 0;
        rd(0, v); chk("R1 rx partial bit0", v, 16'h001F);
        tick();
        chk("R7 masked events no irq", {15'h0, irq}, 16'h0);

        // R5 and R3 repeated reads
        for (int i = 0; i < 4; i++) begin
            rd(i % 2, v); tick();
        end
        rd(0, v); chk("R5 R3 reads leave state", v, 16'h001F);

        // R4 write-one-to-clear
        wr(0, 16'h0000);
        rd(0, v); chk("R4 zero write no effect", v, 16'h001F);
        wr(0, 16'h0011);
        rd(0, v); chk("R4 clear two bits", v, 16'h000E);
        wr(0, 16'hFFFF);
        rd(0, v); chk("R4 clear all", v, 16'h0000);

        // R2 reserved bits, R6 mask load
        wr(1, 16'hFFFF);
        rd(1, v); chk("R2 mask reserved read zero", v, 16'h009F);
        wr(1, 16'h0085);
        rd(1, v); chk("R6 mask readback", v, 16'h0085);
        wr(1, 16'h009F);

        // R7 irq timing
        rx_frame_p = 1; tx_buf_p = 1; tick(); rx_frame_p = 0; tx_buf_p = 0;
        chk("R7 irq not yet", {15'h0, irq}, 16'h0);
        tick();
        chk("R7 irq rises", {15'h0, irq}, 16'h1);
        wr(0, 16'h0008); tick();
        chk("R7 irq held by remaining bit", {15'h0, irq}, 16'h1);
        wr(0, 16'h0002);
        chk("R7 irq one cycle late", {15'h0, irq}, 16'h1);
        tick();
        chk("R7 irq drops", {15'h0, irq}, 16'h0);

        // R7 masked then unmasked
        wr(1, 16'h0008);
        tx_err_p = 1; tick(); tx_err_p = 0;
        tick(); tick();
        chk("R7 masked tx error", {15'h0, irq}, 16'h0);
        wr(1, 16'h0010); tick();
        chk("R7 unmask raises irq", {15'h0, irq}, 16'h1);
        wr(0, 16'h0010); tick();
        chk("R7 cleared", {15'h0, irq}, 16'h0);

        // R8 set wins over clear
        tx_buf_p = 1; bus_we = 1; bus_addr = 0; bus_wdata = 16'h0002;
        tick();
        tx_buf_p = 0; bus_we = 0; bus_wdata = 0;
        rd(0, v); chk("R8 set beats clear", v, 16'h0002);
        wr(0, 16'h0002);
        wr(0, 16'h00FF);

        // R10 immediate graceful stop
        gstop_cmd = 1; tick(); gstop_cmd = 0;
        rd(0, v); chk("R10 immediate done", v, 16'h0080);
        wr(0, 16'h0080);

        // R11 stop during frame
        tx_active = 1; tick();
        gstop_cmd = 1; tick(); gstop_cmd = 0;
        rd(0, v); chk("R11 no done while busy", v, 16'h0000);
        tick(); tick();
        gstop_cmd = 1; tick(); gstop_cmd = 0;
        rd(0, v); chk("R11 extra cmd while draining", v, 16'h0000);
        tx_active = 0; tick();
        rd(0, v); chk("R11 done at frame end", v, 16'h0080);
        wr(0, 16'h0080); tick(); tick();
        rd(0, v); chk("R11 no second event", v, 16'h0000);
        gstop_cmd = 1; tick(); gstop_cmd = 0;
        rd(0, v); chk("R11 back in idle", v, 16'h0080);

        // R9 mid-run reset
        rx_part_p = 1; tick(); rx_part_p = 0; tick();
        rst_n = 0; tick(); rst_n = 1;
        rd(0, v); chk("R9 evt cleared", v, 16'h0000);
        rd(1, v); chk("R9 mask cleared", v, 16'h0000);
        chk("R9 irq cleared", {15'h0, irq}, 16'h0);
        tick();

        finished = 1;
        summary();
        $finish;
    end
endmodule